// File: doc/BRIEF.md
# Saturating Doubling Multiply-Accumulate Vector Unit

This block is a SIMD datapath that widens and accumulates signed products. It takes two 64-bit source vectors of signed narrow elements and one 128-bit vector of signed accumulators, each twice as wide as a source element. Every lane multiplies its two narrow elements and doubles the product. That doubled product saturates only when both operands are the most negative narrow value. The lane then adds the doubled product to its accumulator, or subtracts it, and saturates the result to the wide lane range.

A 1-bit size select picks the lane shape: four 16-bit lanes feeding 32-bit accumulators, or two 32-bit lanes feeding 64-bit accumulators. In scalar mode, one indexed element of the second source is broadcast to every lane. The first source still supplies one element per lane.

Each operation presented with a valid strobe is registered. It appears on the outputs one cycle later, together with a flag that shows whether that operation saturated. A sticky flag collects saturation across operations and is cleared only by a synchronous clear input.

Top module: `sdmac_unit`

## Requirements
- R1: Lane layout follows `esz_sel`.
  - With `esz_sel`=0, lane i (i=0..3) takes `src_a[16i+15:16i]` and `src_b[16i+15:16i]` as signed values, and its accumulator is `acc_in[32i+31:32i]`.
  - With `esz_sel`=1, lane i (i=0..1) takes `src_a[32i+31:32i]` and `src_b[32i+31:32i]`, and its accumulator is `acc_in[64i+63:64i]`.
  - Result lanes in `acc_out` use the same bit positions as the accumulator lanes.
- R2: With `sub_sel`=0, each result lane equals accumulator + 2·a·b whenever no saturation occurs.
- R3: When both operands of a lane equal the most negative narrow value, the doubled product is clamped to the largest positive wide value (0x7FFFFFFF or 0x7FFFFFFFFFFFFFFF) before it is accumulated. This counts as a saturation event.
- R4: With `sub_sel`=1, each result lane equals accumulator − 2·a·b whenever no saturation occurs.
- R5: When the accumulate overflows, the result lane clamps as follows, and this counts as a saturation event:
  - positive overflow gives the largest positive wide value;
  - negative overflow gives the most negative wide value.
- R6: With `scalar_sel`=1, every lane uses the same element of `src_b` as its second operand.
  - For 16-bit elements, that element is index `scalar_idx[1:0]`.
  - For 32-bit elements, it is index `scalar_idx[0]`, and `scalar_idx[1]` is ignored.
- R7: Timing of results.
  - A result and its per-operation saturation flag appear one cycle after a cycle with `in_valid`=1, with `out_valid`=1 for that one cycle.
  - Without `in_valid`, `out_valid` is 0 and `acc_out` and `out_sat` hold their values.
- R8: `out_sat` is 1 with a result exactly when any lane of that operation saturated in either step.
- R9: `sat_sticky` becomes 1 after an operation that saturates. It stays 1 through non-saturating operations until a clear.
- R10: `sat_clr`=1 makes `sat_sticky` 0 on the next cycle. This takes priority over a saturation set in the same cycle.
- R11: While reset is asserted and right after it is released, `out_valid`, `out_sat` and `sat_sticky` are 0 and `acc_out` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operation strobe |
| esz_sel | input | 1 | 0: 16-bit elements, 1: 32-bit elements |
| sub_sel | input | 1 | 0: accumulate by adding, 1: by subtracting |
| scalar_sel | input | 1 | Broadcast one element of `src_b` to all lanes |
| scalar_idx | input | 2 | Broadcast element index |
| src_a | input | 64 | First narrow source vector |
| src_b | input | 64 | Second narrow source vector |
| acc_in | input | 128 | Wide accumulator vector |
| sat_clr | input | 1 | Synchronous clear of the sticky flag |
| out_valid | output | 1 | Result valid |
| acc_out | output | 128 | Updated accumulator vector |
| out_sat | output | 1 | Saturation in the registered operation |
| sat_sticky | output | 1 | Cumulative saturation flag |

## Verification
The bench builds the unit with its default parameters: 64-bit sources and a 16-bit smallest element. This makes both lane shapes reachable, so the 32-bit and 64-bit saturation limits are each hit at their exact edges. The reference model works on wide integers, so it sees the true unclamped value of both the min-times-min product and the accumulator sums that overflow. Directed operations walk every broadcast index in both sizes, including the ignored upper index bit. Seeded random operations then mix sizes, modes and clears against the same model.

// File: rtl/sdmac_pkg.sv
package sdmac_pkg;
  typedef enum logic {
    ESZ_NARROW = 1'b0,
    ESZ_WIDE   = 1'b1
  } esz_e;

  typedef enum logic {
    ACC_ADD = 1'b0,
    ACC_SUB = 1'b1
  } accop_e;
endpackage

// File: rtl/sdmac_rst_sync.sv
module sdmac_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/sdmac_opsel.sv
// Second-operand selection: either the vector as given or one indexed
// element replicated across all lanes of the chosen width.
module sdmac_opsel #(
  parameter int SRC_W = 64,
  parameter int EW    = 16,
  parameter int IW    = 2
) (
  input  logic             scalar_sel,
  input  logic [IW-1:0]    idx,
  input  logic [SRC_W-1:0] src_b,
  output logic [SRC_W-1:0] b_vec
);
  localparam int NL = SRC_W / EW;

  logic [EW-1:0] picked;

  always_comb begin
    picked = src_b[idx*EW +: EW];
  end

  always_comb begin
    if (scalar_sel) b_vec = {NL{picked}};
    else            b_vec = src_b;
  end
endmodule

// File: rtl/sdmac_lane.sv
// One lane: doubled product with its own clamp, then add/sub with a
// second clamp, computed one bit wider than the accumulator.
module sdmac_lane #(
  parameter int EW = 16
) (
  input  logic [EW-1:0]   op_a,
  input  logic [EW-1:0]   op_b,
  input  logic [2*EW-1:0] acc,
  input  logic            sub,
  output logic [2*EW-1:0] res,
  output logic            sat_mul,
  output logic            sat_acc
);
  localparam int PW = 2 * EW;
  localparam logic [EW-1:0] NMIN = {1'b1, {(EW-1){1'b0}}};
  localparam logic [PW-1:0] WMAX = {1'b0, {(PW-1){1'b1}}};
  localparam logic [PW-1:0] WMIN = {1'b1, {(PW-1){1'b0}}};

  logic signed [PW-1:0] a_x, b_x, prod, dbl;
  logic signed [PW:0]   acc_x, dbl_x, sum;

  always_comb begin
    a_x     = PW'($signed(op_a));
    b_x     = PW'($signed(op_b));
    prod    = a_x * b_x;
    sat_mul = (op_a == NMIN) && (op_b == NMIN);
    dbl     = sat_mul ? $signed(WMAX) : (prod <<< 1);
  end

  always_comb begin
    acc_x = {acc[PW-1], acc};
    dbl_x = {dbl[PW-1], dbl};
    sum   = sub ? (acc_x - dbl_x) : (acc_x + dbl_x);
    sat_acc = sum[PW] ^ sum[PW-1];
    if (sat_acc) res = sum[PW] ? WMIN : WMAX;
    else         res = sum[PW-1:0];
  end
endmodule

// File: rtl/sdmac_unit.sv
module sdmac_unit #(
  parameter int SRC_W = 64,
  parameter int EL_W  = 16,
  parameter int IDX_W = $clog2(SRC_W / EL_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic               esz_sel,
  input  logic               sub_sel,
  input  logic               scalar_sel,
  input  logic [IDX_W-1:0]   scalar_idx,
  input  logic [SRC_W-1:0]   src_a,
  input  logic [SRC_W-1:0]   src_b,
  input  logic [2*SRC_W-1:0] acc_in,
  input  logic               sat_clr,
  output logic               out_valid,
  output logic [2*SRC_W-1:0] acc_out,
  output logic               out_sat,
  output logic               sat_sticky
);
  import sdmac_pkg::*;

  localparam int ACC_W = 2 * SRC_W;
  localparam int EW_S  = EL_W;
  localparam int EW_L  = 2 * EL_W;
  localparam int NL_S  = SRC_W / EW_S;
  localparam int NL_L  = SRC_W / EW_L;
  localparam int IW_L  = (IDX_W > 1) ? IDX_W - 1 : 1;

  logic rst_sync_n;

  sdmac_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // Operand selection per element size
  logic [SRC_W-1:0] b_s, b_l;

  sdmac_opsel #(.SRC_W(SRC_W), .EW(EW_S), .IW(IDX_W)) u_sel_s (
    .scalar_sel (scalar_sel),
    .idx        (scalar_idx),
    .src_b      (src_b),
    .b_vec      (b_s)
  );

  sdmac_opsel #(.SRC_W(SRC_W), .EW(EW_L), .IW(IW_L)) u_sel_l (
    .scalar_sel (scalar_sel),
    .idx        (scalar_idx[IW_L-1:0]),
    .src_b      (src_b),
    .b_vec      (b_l)
  );

  // Lane arrays for both sizes
  logic [ACC_W-1:0] res_s, res_l;
  logic [NL_S-1:0]  mul_s, add_s;
  logic [NL_L-1:0]  mul_l, add_l;
  logic             is_sub;

  assign is_sub = (accop_e'(sub_sel) == ACC_SUB);

  for (genvar i = 0; i < NL_S; i++) begin : g_small
    sdmac_lane #(.EW(EW_S)) u_lane (
      .op_a    (src_a[i*EW_S +: EW_S]),
      .op_b    (b_s[i*EW_S +: EW_S]),
      .acc     (acc_in[i*2*EW_S +: 2*EW_S]),
      .sub     (is_sub),
      .res     (res_s[i*2*EW_S +: 2*EW_S]),
      .sat_mul (mul_s[i]),
      .sat_acc (add_s[i])
    );
  end

  for (genvar i = 0; i < NL_L; i++) begin : g_large
    sdmac_lane #(.EW(EW_L)) u_lane (
      .op_a    (src_a[i*EW_L +: EW_L]),
      .op_b    (b_l[i*EW_L +: EW_L]),
      .acc     (acc_in[i*2*EW_L +: 2*EW_L]),
      .sub     (is_sub),
      .res     (res_l[i*2*EW_L +: 2*EW_L]),
      .sat_mul (mul_l[i]),
      .sat_acc (add_l[i])
    );
  end

  // Next-state logic
  logic [ACC_W-1:0] acc_d, acc_q;
  logic             any_sat;
  logic             sat_d, sat_q, stk_d, stk_q, vld_q;

  always_comb begin
    if (esz_e'(esz_sel) == ESZ_WIDE) begin
      any_sat = |{mul_l, add_l};
    end else begin
      any_sat = |{mul_s, add_s};
    end
  end

  always_comb begin
    acc_d = acc_q;
    sat_d = sat_q;
    if (in_valid) begin
      acc_d = (esz_e'(esz_sel) == ESZ_WIDE) ? res_l : res_s;
      sat_d = any_sat;
    end
  end

  always_comb begin
    stk_d = stk_q;
    if (sat_clr)                  stk_d = 1'b0;
    else if (in_valid && any_sat) stk_d = 1'b1;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      acc_q <= '0;
      sat_q <= 1'b0;
      stk_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      sat_q <= sat_d;
      stk_q <= stk_d;
      vld_q <= in_valid;
    end
  end

  assign acc_out    = acc_q;
  assign out_sat    = sat_q;
  assign sat_sticky = stk_q;
  assign out_valid  = vld_q;

  // Assertions
  assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> out_valid);

  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> (!out_valid && $stable(acc_out) && $stable(out_sat)));

  assert_sticky_keep_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sat_sticky && !sat_clr) |=> sat_sticky);

  assert_sticky_with_result_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && !sat_clr) |=> (!out_sat || sat_sticky));

  assert_clear_wins_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sat_clr |=> !sat_sticky);
endmodule

// File: tb/tb_sdmac_unit.sv
module tb_sdmac_unit;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid, esz_sel, sub_sel, scalar_sel, sat_clr;
  logic [1:0]   scalar_idx;
  logic [63:0]  src_a, src_b;
  logic [127:0] acc_in;
  logic         out_valid, out_sat, sat_sticky;
  logic [127:0] acc_out;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  sdmac_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .esz_sel(esz_sel),
    .sub_sel(sub_sel), .scalar_sel(scalar_sel), .scalar_idx(scalar_idx),
    .src_a(src_a), .src_b(src_b), .acc_in(acc_in), .sat_clr(sat_clr),
    .out_valid(out_valid), .acc_out(acc_out), .out_sat(out_sat),
    .sat_sticky(sat_sticky)
  );

  typedef struct {
    logic [127:0] acc;
    bit           sat;
    bit           stk;
    string        tag;
  } exp_t;

  exp_t         sb[$];
  bit           stk_model = 0;
  logic [127:0] last_acc  = '0;
  bit           last_sat  = 0;

  task automatic chk(bit ok, string tag, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic signed [131:0] sx(logic [127:0] v, int pos, int w);
    logic signed [131:0] one, t;
    one = 1;
    t = 132'(v >> pos) & ((one <<< w) - 1);
    if (t[w-1]) t = t - (one <<< w);
    return t;
  endfunction

  // Wide-integer reference: returns {sat, result}
  function automatic logic [128:0] ref_op(bit esz, bit sub, bit scal, logic [1:0] idx,
                                         logic [63:0] a, logic [63:0] b, logic [127:0] acc);
    logic signed [131:0] one, x, y, c, p, r, hi, lo;
    logic [127:0] res, m2;
    bit sat;
    int ew, n, k;
    one = 1;
    ew  = esz ? 32 : 16;
    n   = 64 / ew;
    k   = esz ? int'(idx[0]) : int'(idx);
    hi  = (one <<< (2*ew-1)) - 1;
    lo  = -(one <<< (2*ew-1));
    m2  = 128'((one <<< (2*ew)) - 1);
    res = '0;
    sat = 0;
    for (int i = 0; i < n; i++) begin
      x = sx({64'd0, a}, i*ew, ew);
      y = scal ? sx({64'd0, b}, k*ew, ew) : sx({64'd0, b}, i*ew, ew);
      c = sx(acc, i*2*ew, 2*ew);
      p = 2 * x * y;
      if (p > hi) begin p = hi; sat = 1; end
      r = sub ? c - p : c + p;
      if (r > hi) begin r = hi; sat = 1; end
      if (r < lo) begin r = lo; sat = 1; end
      res = res | ((128'(r) & m2) << (i*2*ew));
    end
    return {sat, res};
  endfunction

  task automatic op(bit esz, bit sub, bit scal, logic [1:0] idx, logic [63:0] a,
                    logic [63:0] b, logic [127:0] acc, bit clr, string tag);
    logic [128:0] r;
    exp_t e;
    r = ref_op(esz, sub, scal, idx, a, b, acc);
    stk_model = clr ? 1'b0 : (stk_model | r[128]);
    e.acc = r[127:0]; e.sat = r[128]; e.stk = stk_model; e.tag = tag;
    sb.push_back(e);
    esz_sel = esz; sub_sel = sub; scalar_sel = scal; scalar_idx = idx;
    src_a = a; src_b = b; acc_in = acc; sat_clr = clr; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; sat_clr = 1'b0;
  endtask

  // Monitor
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (sb.size() == 0) begin
        chk(0, "R7", "unexpected out_valid", 128'(out_valid), 128'(0));
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(acc_out === e.acc, e.tag, "acc_out", acc_out, e.acc);
        chk(out_sat === e.sat, {e.tag, "/R8"}, "out_sat", 128'(out_sat), 128'(e.sat));
        chk(sat_sticky === e.stk, {e.tag, "/R9"}, "sat_sticky", 128'(sat_sticky), 128'(e.stk));
        last_acc = e.acc; last_sat = e.sat;
      end
    end
  end

  task automatic drain;
    @(negedge clk);
    while (sb.size() != 0) @(negedge clk);
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst_n = 1'b0; in_valid = 0; esz_sel = 0; sub_sel = 0; scalar_sel = 0;
    scalar_idx = 0; src_a = 0; src_b = 0; acc_in = 0; sat_clr = 0;
    repeat (3) @(negedge clk);
    // R11 during reset
    chk(!out_valid && !out_sat && !sat_sticky && acc_out == '0, "R11", "reset outputs",
        {out_valid, out_sat, sat_sticky, acc_out[124:0]}, '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!out_valid && !out_sat && !sat_sticky && acc_out == '0, "R11", "after release",
        {out_valid, out_sat, sat_sticky, acc_out[124:0]}, '0);

    // R1/R2 basic add, both sizes
    op(0, 0, 0, 0, 64'h0003_FFFF_0100_0007, 64'h0005_0002_FF00_0009,
       128'h0000_0010_0000_0020_FFFF_FFF0_0000_0001, 0, "R1/R2");
    op(1, 0, 0, 0, 64'hFFFF_FFFE_0001_0000, 64'h0000_0003_0001_0000,
       128'h0000_0000_0000_0005_FFFF_FFFF_FFFF_FFFF, 0, "R1/R2");
    // R4 subtract
    op(0, 1, 0, 0, 64'h7FFF_0002_FFFD_1234, 64'h7FFF_0003_0004_0010,
       128'h1000_0000_0000_0000_0000_0000_0000_0100, 0, "R4");
    op(1, 1, 0, 0, 64'h1234_5678_8000_0001, 64'h0000_0010_7FFF_FFFF,
       128'h0, 0, "R4");
    // R3 min x min, both sizes, add and sub
    op(0, 0, 0, 0, 64'h8000_8000_0001_0000, 64'h8000_0001_0001_0000, 128'h0, 0, "R3");
    op(0, 1, 0, 0, 64'h0000_0000_0000_8000, 64'h0000_0000_0000_8000, 128'h0, 1, "R3/R10");
    op(1, 0, 0, 0, 64'h0000_0001_8000_0000, 64'h0000_0001_8000_0000, 128'h0, 0, "R3");
    op(1, 1, 0, 0, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000,
       128'h0000_0000_0000_0001_0000_0000_0000_0000, 0, "R3");
    // R9 non-saturating op keeps sticky
    op(0, 0, 0, 0, 64'h1, 64'h1, 128'h0, 0, "R9");
    // R10 clear with saturating op same cycle
    op(0, 0, 0, 0, 64'h8000, 64'h8000, 128'h0, 1, "R10");
    // R5 positive and negative accumulate overflow
    op(0, 0, 0, 0, 64'h0000_0000_0000_7FFF, 64'h0000_0000_0000_7FFF,
       128'h0000_0000_0000_0000_0000_0000_7FFF_0000, 0, "R5");
    op(0, 1, 0, 0, 64'h0000_0000_7FFF_0000, 64'h0000_0000_7FFF_0000,
       128'h0000_0000_0000_0000_8000_1000_0000_0000, 1, "R5");
    op(1, 0, 0, 0, 64'h0000_0000_7FFF_FFFF, 64'h0000_0000_0000_0002,
       128'h0000_0000_0000_0000_7FFF_FFFF_FFFF_FFF0, 1, "R5");
    op(1, 1, 0, 0, 64'h0000_0002_0000_0000, 64'h0000_0003_0000_0000,
       128'h8000_0000_0000_0005_0000_0000_0000_0000, 1, "R5");
    // R6 scalar at every index
    for (int k = 0; k < 4; k++)
      op(0, k[0], 1, 2'(k), 64'h0004_FFFD_0102_8000, 64'h8000_0300_FFFF_0011,
         128'h0000_0100_0000_0200_FFFF_0000_0000_0300, 0, "R6");
    for (int k = 0; k < 4; k++)
      op(1, 0, 1, 2'(k), 64'h8000_0000_0000_0042, 64'h8000_0000_0000_0005,
         128'h0000_0000_0000_1000_0000_0000_0000_2000, 0, "R6");
    // seeded random mix
    for (int k = 0; k < 24; k++)
      op(1'($urandom), 1'($urandom), 1'($urandom), 2'($urandom),
         {$urandom, $urandom}, {$urandom, $urandom},
         {$urandom, $urandom, $urandom, $urandom}, ($urandom % 6) == 0, "R2/R4");
    drain();

    // R7 hold while idle with changing inputs
    src_a = 64'hDEAD_BEEF_0000_1111; acc_in = '1; esz_sel = ~esz_sel;
    repeat (3) @(negedge clk);
    chk(!out_valid, "R7", "out_valid idle", 128'(out_valid), 128'(0));
    chk(acc_out === last_acc, "R7", "acc_out hold", acc_out, last_acc);
    chk(out_sat === last_sat, "R7", "out_sat hold", 128'(out_sat), 128'(last_sat));

    // R10 clear alone, after forcing sticky set
    op(0, 0, 0, 0, 64'h8000, 64'h8000, 128'h0, 0, "R9");
    drain();
    sat_clr = 1'b1;
    @(negedge clk);
    sat_clr = 1'b0;
    chk(!sat_sticky, "R10", "clear alone", 128'(sat_sticky), 128'(0));
    chk(acc_out === last_acc, "R10", "acc kept on clear", acc_out, last_acc);
    stk_model = 0;

    summary();
  end
endmodule